// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip sink for a stream of 32-bit trace words. While capture is enabled, every valid word on the trace input is written into a circular RAM at the write pointer, and the pointer moves on by one. When the pointer passes the last entry it returns to zero and a sticky full flag records that older words have been overwritten. A host reaches the buffer through a simple register port with a 12-bit word-aligned address. It can set both pointers, write the RAM directly through a write-data register, and drain it through a read-data register. Each access to either data register moves its own pointer forward.

Two controls end a capture session cleanly. With stop-on-trigger armed, a trace word that arrives with the trigger strobe starts a countdown of a programmed length. Once that many further words have been stored, capture halts. A manual flush request fills the current partial frame with zero words until the write pointer sits on a 4-word frame boundary. The request bit then clears itself. If stop-on-flush is armed, capture also halts at that point. A host write to the control register rearms a halted buffer.

Register offsets: 0x004 depth (read-only), 0x00C status, 0x010 read data, 0x014 read pointer, 0x018 write pointer, 0x01C trigger count, 0x020 control, 0x024 write data, 0x300 stop status, 0x304 stop control. Any other offset reads as zero. DEPTH must be a power of two.

Top module: `tracebuf_top`

## Requirements
- R1: After reset the pointers, control bit, trigger count, stop-control bits, flush request, stopped flag and full flag are all zero, and regRdata reads 0.
- R2: A read of offset 0x004 returns DEPTH with bit 31 clear. A read of an unmapped offset returns 0.
- R3: A word with trcValid high is stored at the write pointer, and the pointer advances, only while control bit 0 (offset 0x020) is 1, the buffer is not stopped and no flush is pending. Otherwise the write pointer holds.
- R4: A host write to offset 0x024 stores regWdata at the write pointer and advances it. It takes priority over a trace word in the same cycle, and that trace word is dropped.
- R5: A read of offset 0x010 returns the RAM word at the read pointer and advances the pointer. Every read result appears on regRdata one cycle after the cycle in which regRe is high, and it holds until the next read.
- R6: Offsets 0x014 and 0x018 read and write the read and write pointers as word indices. Incrementing either pointer wraps from DEPTH-1 to 0.
- R7: Status bit 0 (offset 0x00C) sets when any write advances the write pointer from DEPTH-1 to 0. It stays set until the host writes the write pointer, which clears it.
- R8: With stop-control bit 13 (offset 0x304) set, the first stored word that carries trcTrig starts a countdown loaded from the trigger count. After exactly that many further stored words, capture stops and stop-status bit 1 (offset 0x300) reads 1.
- R9: Writing 1 to stop-control bit 6 requests a flush. While the request is pending, bit 6 and stop-status bit 0 read 1, trace words are dropped, and one zero word per cycle is written until the write pointer is a multiple of 4. The request then clears itself.
- R10: With stop-control bit 12 set, the completion of a flush stops capture. Any host write to offset 0x020 clears the stopped state and the trigger countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Host register write strobe |
| regRe | input | 1 | Host register read strobe |
| regAddr | input | 12 | Host byte offset |
| regWdata | input | 32 | Host write data |
| regRdata | output | 32 | Registered host read data |
| trcValid | input | 1 | Trace word valid |
| trcData | input | 32 | Trace word |
| trcTrig | input | 1 | Trigger strobe qualifying the current trace word |

## Verification
Every register effect lands on the clock edge that samples the strobe. A read issued in the next cycle therefore sees a new pointer, flag or RAM word, and its value is on regRdata one further cycle later. Flush padding moves the write pointer by one per cycle, so the end of a flush depends on how far the pointer sat from a frame boundary. The bench keeps a behavioural model that takes the same inputs at each rising edge and applies these latencies. It compares regRdata with the model at every falling edge. Each comparison is tagged with the requirement of the most recent read, so a mismatch shows up in the exact cycle in which the read result is due.

// File: rtl/tracebuf_pkg.sv
package tracebuf_pkg;
  localparam int BUS_W = 32;
  localparam int FRAME_WORDS = 4;

  localparam logic [11:0] A_DEPTH = 12'h004;
  localparam logic [11:0] A_STAT  = 12'h00C;
  localparam logic [11:0] A_RDATA = 12'h010;
  localparam logic [11:0] A_RDPTR = 12'h014;
  localparam logic [11:0] A_WRPTR = 12'h018;
  localparam logic [11:0] A_TRIG  = 12'h01C;
  localparam logic [11:0] A_CTRL  = 12'h020;
  localparam logic [11:0] A_WDATA = 12'h024;
  localparam logic [11:0] A_FSTAT = 12'h300;
  localparam logic [11:0] A_FCTRL = 12'h304;

  // stop-control bit positions
  localparam int FC_FLUSH   = 6;
  localparam int FC_STOPFL  = 12;
  localparam int FC_STOPTRG = 13;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_HOST  = 2'd1,
    SRC_PAD   = 2'd2,
    SRC_TRACE = 2'd3
  } wsrc_e;

  typedef struct packed {
    wsrc_e wrSrc;   // which word, if any, goes into the RAM this cycle
    logic  wrLoad;  // host loads the write pointer
    logic  rdLoad;  // host loads the read pointer
    logic  rdStep;  // read-data access advances the read pointer
  } strobe_t;
endpackage

// File: rtl/tracebuf_ctrl.sv
module tracebuf_ctrl
  import tracebuf_pkg::*;
#(
  parameter int TRIG_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [11:0]       regAddr,
  input  logic [BUS_W-1:0]  regWdata,
  input  logic              trcValid,
  input  logic              trcTrig,
  input  logic              wrAligned,
  output strobe_t           strb,
  output logic              capEn,
  output logic [TRIG_W-1:0] trigCnt,
  output logic              stopOnTrig,
  output logic              stopOnFlush,
  output logic              flushBusy,
  output logic              stopped
);
  logic              triggered;
  logic [TRIG_W-1:0] remain;
  logic hostWrPtr, hostWdata, ctrlWr, trigWr, fctlWr;
  logic padNow, accept, flushDone, trigFire, trigCount, trigStop;
  logic unusedWd;

  assign unusedWd  = ^regWdata;
  assign hostWrPtr = regWe && (regAddr == A_WRPTR);
  assign hostWdata = regWe && (regAddr == A_WDATA);
  assign ctrlWr    = regWe && (regAddr == A_CTRL);
  assign trigWr    = regWe && (regAddr == A_TRIG);
  assign fctlWr    = regWe && (regAddr == A_FCTRL);

  assign padNow    = flushBusy && !wrAligned && !hostWrPtr && !hostWdata;
  assign flushDone = flushBusy &&  wrAligned && !hostWrPtr && !hostWdata;
  assign accept    = capEn && trcValid && !stopped && !flushBusy
                     && !hostWrPtr && !hostWdata;

  assign trigFire  = accept && stopOnTrig && !triggered && trcTrig;
  assign trigCount = accept && stopOnTrig && triggered;
  assign trigStop  = (trigFire && (trigCnt == '0))
                   || (trigCount && (remain == TRIG_W'(1)));

  always_comb begin
    strb.wrLoad = hostWrPtr;
    strb.rdLoad = regWe && (regAddr == A_RDPTR);
    strb.rdStep = regRe && (regAddr == A_RDATA);
    if (hostWdata)   strb.wrSrc = SRC_HOST;
    else if (padNow) strb.wrSrc = SRC_PAD;
    else if (accept) strb.wrSrc = SRC_TRACE;
    else             strb.wrSrc = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capEn       <= 1'b0;
      trigCnt     <= '0;
      stopOnTrig  <= 1'b0;
      stopOnFlush <= 1'b0;
      flushBusy   <= 1'b0;
      stopped     <= 1'b0;
      triggered   <= 1'b0;
      remain      <= '0;
    end else begin
      if (ctrlWr) capEn <= regWdata[0];
      if (trigWr) trigCnt <= regWdata[TRIG_W-1:0];
      if (fctlWr) begin
        stopOnTrig  <= regWdata[FC_STOPTRG];
        stopOnFlush <= regWdata[FC_STOPFL];
      end
      if (fctlWr && regWdata[FC_FLUSH]) flushBusy <= 1'b1;
      else if (flushDone)               flushBusy <= 1'b0;
      if (ctrlWr) begin
        stopped   <= 1'b0;
        triggered <= 1'b0;
      end else begin
        if (trigFire) begin
          triggered <= 1'b1;
          remain    <= trigCnt;
        end else if (trigCount) begin
          remain <= remain - TRIG_W'(1);
        end
        if ((flushDone && stopOnFlush) || trigStop) stopped <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tracebuf_dp.sv
module tracebuf_dp
  import tracebuf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [BUS_W-1:0] hostData,
  input  logic [BUS_W-1:0] trcData,
  input  logic [AW-1:0]    loadVal,
  output logic [AW-1:0]    wrPtr,
  output logic [AW-1:0]    rdPtr,
  output logic             full,
  output logic             wrAligned,
  output logic [BUS_W-1:0] rdWord
);
  logic [BUS_W-1:0] mem [DEPTH];
  logic [BUS_W-1:0] wrData;
  logic             ramWe;

  assign ramWe     = (strb.wrSrc != SRC_NONE);
  assign wrAligned = (wrPtr[$clog2(FRAME_WORDS)-1:0] == '0);
  assign rdWord    = mem[rdPtr];

  always_comb begin
    case (strb.wrSrc)
      SRC_HOST:  wrData = hostData;
      SRC_TRACE: wrData = trcData;
      default:   wrData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ramWe) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      full  <= 1'b0;
    end else begin
      if (strb.wrLoad) begin
        wrPtr <= loadVal;
        full  <= 1'b0;
      end else if (ramWe) begin
        wrPtr <= wrPtr + AW'(1);
        if (&wrPtr) full <= 1'b1;
      end
      if (strb.rdLoad)      rdPtr <= loadVal;
      else if (strb.rdStep) rdPtr <= rdPtr + AW'(1);
    end
  end
endmodule

// File: rtl/tracebuf_top.sv
module tracebuf_top
  import tracebuf_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int TRIG_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regRe,
  input  logic [11:0] regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        trcValid,
  input  logic [31:0] trcData,
  input  logic        trcTrig
);
  localparam int AW = $clog2(DEPTH);

  strobe_t           strb;
  logic [AW-1:0]     wrPtr, rdPtr;
  logic              full, wrAligned, capEn, stopOnTrig, stopOnFlush;
  logic              flushBusy, stopped;
  logic [TRIG_W-1:0] trigCnt;
  logic [BUS_W-1:0]  rdWord, rdMux;

  tracebuf_ctrl #(.TRIG_W(TRIG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .trcValid(trcValid),
    .trcTrig(trcTrig), .wrAligned(wrAligned), .strb(strb),
    .capEn(capEn), .trigCnt(trigCnt), .stopOnTrig(stopOnTrig),
    .stopOnFlush(stopOnFlush), .flushBusy(flushBusy), .stopped(stopped)
  );

  tracebuf_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostData(regWdata),
    .trcData(trcData), .loadVal(regWdata[AW-1:0]), .wrPtr(wrPtr),
    .rdPtr(rdPtr), .full(full), .wrAligned(wrAligned), .rdWord(rdWord)
  );

  always_comb begin
    rdMux = '0;
    case (regAddr)
      A_DEPTH: rdMux = BUS_W'(DEPTH);
      A_STAT:  rdMux[0] = full;
      A_RDATA: rdMux = rdWord;
      A_RDPTR: rdMux = BUS_W'(rdPtr);
      A_WRPTR: rdMux = BUS_W'(wrPtr);
      A_TRIG:  rdMux = BUS_W'(trigCnt);
      A_CTRL:  rdMux[0] = capEn;
      A_FSTAT: begin
        rdMux[0] = flushBusy;
        rdMux[1] = stopped;
      end
      A_FCTRL: begin
        rdMux[FC_FLUSH]   = flushBusy;
        rdMux[FC_STOPFL]  = stopOnFlush;
        rdMux[FC_STOPTRG] = stopOnTrig;
      end
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      regRdata <= '0;
    else if (regRe) regRdata <= rdMux;
  end
endmodule

// File: rtl/tracebuf_chk.sv
module tracebuf_chk
  import tracebuf_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWe,
  input logic [11:0]   regAddr,
  input logic [AW-1:0] wrPtr,
  input logic          full,
  input logic          capEn,
  input logic          flushBusy,
  input logic          stopped
);
  // R7
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    full && !(regWe && regAddr == A_WRPTR) |=> full);

  // R7
  full_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == A_WRPTR |=> !full);

  // R6
  wrptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == A_WRPTR)
    |=> (wrPtr == $past(wrPtr)) || (wrPtr == AW'($past(wrPtr) + AW'(1))));

  // R9
  flush_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flushBusy) |-> wrPtr[1:0] == 2'b00);

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopped && !(regWe && regAddr == A_CTRL) |=> stopped);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !capEn && !flushBusy
    && !(regWe && (regAddr == A_WRPTR || regAddr == A_WDATA))
    |=> $stable(wrPtr));
endmodule

bind tracebuf_top tracebuf_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .wrPtr(wrPtr), .full(full), .capEn(capEn), .flushBusy(flushBusy),
  .stopped(stopped)
);

// File: tb/tb_tracebuf_top.sv
`timescale 1ns/1ps
module tb_tracebuf_top;
  localparam int D = 256;
  localparam logic [11:0] ADEP = 12'h004, ASTA = 12'h00C, ARDD = 12'h010,
    ARDP = 12'h014, AWRP = 12'h018, ATRG = 12'h01C, ACTL = 12'h020,
    AWRD = 12'h024, AFST = 12'h300, AFCT = 12'h304;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0, regRe = 1'b0, trcValid = 1'b0, trcTrig = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0, trcData = '0;
  logic [31:0] regRdata;

  always #5 clk = ~clk;

  tracebuf_top dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .trcValid(trcValid), .trcData(trcData), .trcTrig(trcTrig)
  );

  // behavioural reference state
  logic [31:0] mMem [0:D-1];
  int mWp, mRp, mTrig, mRemain;
  bit mFull, mEn, mStopT, mStopF, mBusy, mStop, mArmed;
  logic [31:0] rdExp;
  int tests = 0, fails = 0, cycles = 0;
  string curTag = "R1";
  bit done = 1'b0;

  initial for (int i = 0; i < D; i++) mMem[i] = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mWp = 0; mRp = 0; mTrig = 0; mRemain = 0; mFull = 0; mEn = 0;
      mStopT = 0; mStopF = 0; mBusy = 0; mStop = 0; mArmed = 0; rdExp = '0;
    end else begin
      bit hWp, hWd, cW, aligned, pad, acc, fin, nStop, nArmed, nBusy;
      int nRemain;
      hWp = regWe && regAddr == AWRP;
      hWd = regWe && regAddr == AWRD;
      cW  = regWe && regAddr == ACTL;
      aligned = (mWp % 4) == 0;
      pad = mBusy && !aligned && !hWp && !hWd;
      fin = mBusy && aligned && !hWp && !hWd;
      acc = mEn && trcValid && !mStop && !mBusy && !hWp && !hWd;
      if (regRe) begin
        case (regAddr)
          ADEP: rdExp = D;
          ASTA: rdExp = {31'd0, mFull};
          ARDD: rdExp = mMem[mRp];
          ARDP: rdExp = mRp;
          AWRP: rdExp = mWp;
          ATRG: rdExp = mTrig;
          ACTL: rdExp = {31'd0, mEn};
          AFST: rdExp = {30'd0, mStop, mBusy};
          AFCT: rdExp = (mStopT << 13) | (mStopF << 12) | (mBusy << 6);
          default: rdExp = '0;
        endcase
      end
      nStop = mStop; nArmed = mArmed; nRemain = mRemain; nBusy = mBusy;
      if (cW) begin
        nStop = 0; nArmed = 0;
      end else begin
        if (acc && mStopT) begin
          if (!mArmed && trcTrig) begin
            nArmed = 1; nRemain = mTrig;
            if (mTrig == 0) nStop = 1;
          end else if (mArmed) begin
            nRemain = mRemain - 1;
            if (nRemain == 0) nStop = 1;
          end
        end
        if (fin && mStopF) nStop = 1;
      end
      if (fin) nBusy = 0;
      if (regWe && regAddr == AFCT) begin
        if (regWdata[6]) nBusy = 1;
        mStopT = regWdata[13]; mStopF = regWdata[12];
      end
      if (cW) mEn = regWdata[0];
      if (regWe && regAddr == ATRG) mTrig = regWdata[15:0];
      if (regWe && regAddr == ARDP) mRp = regWdata[7:0];
      else if (regRe && regAddr == ARDD) mRp = (mRp + 1) % D;
      if (hWp) begin
        mWp = regWdata[7:0]; mFull = 0;
      end else if (hWd || pad || acc) begin
        mMem[mWp] = hWd ? regWdata : (pad ? 32'd0 : trcData);
        if (mWp == D - 1) mFull = 1;
        mWp = (mWp + 1) % D;
      end
      mStop = nStop; mArmed = nArmed; mRemain = nRemain; mBusy = nBusy;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      tests++;
      if (regRdata !== rdExp) begin
        fails++;
        $display("FAIL %s: regRdata actual %h expected %h at %0t",
                 curTag, regRdata, rdExp, $time);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    curTag = tag; regRe = 1'b1; regAddr = a;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic trc(input logic v, input logic [31:0] d, input logic t);
    trcValid = v; trcData = d; trcTrig = t;
    @(negedge clk);
    trcValid = 1'b0; trcTrig = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rd(ASTA, "R1"); rd(ARDP, "R1"); rd(AWRP, "R1"); rd(ACTL, "R1");
    rd(AFST, "R1"); rd(AFCT, "R1"); rd(ATRG, "R1");
    // R2 depth and unmapped
    rd(ADEP, "R2"); rd(12'h0FC, "R2"); rd(12'h308, "R2");
    // R4 host fill, R7 wrap flag
    for (int i = 0; i < D; i++) wr(AWRD, 32'h1000_0000 + i * 3);
    rd(ASTA, "R7"); rd(AWRP, "R6");
    wr(AWRP, 0); rd(ASTA, "R7");
    // R5/R6 read-back across the wrap
    wr(ARDP, 250);
    for (int i = 0; i < 8; i++) rd(ARDD, "R5");
    rd(ARDP, "R6"); rd(ARDP, "R5");
    // R3 capture with gaps
    wr(ACTL, 1);
    for (int i = 0; i < 10; i++) begin
      trc(1'b1, 32'hA000_0000 + i, 1'b0);
      if (i % 3 == 0) trc(1'b0, 32'hDEAD_0000, 1'b0);
    end
    rd(AWRP, "R3");
    wr(ACTL, 0);
    for (int i = 0; i < 3; i++) trc(1'b1, 32'hBAD0_0000 + i, 1'b0);
    rd(AWRP, "R3");
    wr(ARDP, 0);
    for (int i = 0; i < 11; i++) rd(ARDD, "R3");
    // R4 host write beats trace word in the same cycle
    wr(ACTL, 1);
    trcValid = 1'b1; trcData = 32'hCCCC_0001;
    wr(AWRD, 32'h5555_AAAA);
    trcValid = 1'b0;
    rd(AWRP, "R4"); wr(ARDP, 10); rd(ARDD, "R4"); rd(ARDD, "R4");
    // R9 flush pads to frame boundary, trace blocked meanwhile
    wr(AFCT, 32'h40);
    trcValid = 1'b1; trcData = 32'hEEEE_0000;
    rd(AFCT, "R9"); rd(AFST, "R9");
    trcValid = 1'b0;
    rd(AFCT, "R9"); rd(AFST, "R9"); rd(AWRP, "R9");
    wr(ARDP, 10);
    for (int i = 0; i < 3; i++) rd(ARDD, "R9");
    // R8 stop after trigger countdown of 3
    wr(ATRG, 3); wr(AFCT, 32'h2000); wr(ACTL, 1); rd(ATRG, "R8");
    trc(1'b1, 32'h1, 1'b0); trc(1'b1, 32'h2, 1'b0);
    trc(1'b1, 32'h3, 1'b1);
    for (int i = 0; i < 6; i++) trc(1'b1, 32'h10 + i, 1'b0);
    rd(AFST, "R8"); rd(AWRP, "R8");
    // R10 control write rearms
    wr(ACTL, 1); rd(AFST, "R10");
    // R8 countdown of zero
    wr(ATRG, 0); rd(AFCT, "R8");
    trc(1'b1, 32'h20, 1'b1); trc(1'b1, 32'h21, 1'b0); trc(1'b1, 32'h22, 1'b0);
    rd(AWRP, "R8"); rd(AFST, "R8");
    // R10 stop on flush
    wr(ACTL, 1); trc(1'b1, 32'h30, 1'b0);
    wr(AFCT, 32'h1040);
    repeat (5) @(negedge clk);
    rd(AFST, "R10"); rd(AFCT, "R10");
    trc(1'b1, 32'h31, 1'b0); rd(AWRP, "R10");
    // R7 wrap by capture, then clear
    wr(AFCT, 0); wr(ACTL, 1); wr(AWRP, 250); rd(ASTA, "R7");
    for (int i = 0; i < 10; i++) trc(1'b1, 32'h7000 + i, 1'b0);
    rd(ASTA, "R7"); rd(AWRP, "R6");
    wr(ARDP, 254);
    for (int i = 0; i < 4; i++) rd(ARDD, "R6");
    wr(AWRP, 3); rd(ASTA, "R7"); rd(AWRP, "R6");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule